// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits between the command decoder of a synchronous DRAM controller and the column path. When a read or write is accepted, it captures the starting column, the burst length code, the wrap order and the full-page selection. From the next clock onward it presents one column address per cycle until the burst is complete.

Fixed-length bursts of 1, 2, 4 or 8 beats wrap inside the aligned block that holds the starting column. The wrap follows either an incrementing order or an XOR-interleaved order. A full-page burst walks the whole 11-bit column space in incrementing order and keeps going until it is stopped. A terminate strobe ends any burst. A new accepted start request mid-burst restarts generation from its own column. Start requests with an unsupported configuration are dropped and leave a sticky error flag set.

Top module: `burst_col_gen`

## Requirements
- R1: An accepted start request (start_i high, supported configuration) makes valid_o high in the following cycle, and col_o in that cycle equals the captured col_i.
- R2: burst_len_i selects the fixed burst length as 0 → 1 beat, 1 → 2, 2 → 4 and 3 → 8. A fixed burst presents exactly that many valid beats, and valid_o is low in the cycle after the last beat unless a new burst was accepted.
- R3: With wrap_ilv_i = 0 (incrementing order), beat i of a fixed burst of length L = 2^k has col_o[k-1:0] = (start[k-1:0] + i) mod L. Bits [10:k] equal those of the start column.
- R4: With wrap_ilv_i = 1 (interleaved order), beat i of a fixed burst has col_o[k-1:0] = start[k-1:0] XOR i. Bits [10:k] equal those of the start column.
- R5: With page_mode_i = 1 and wrap_ilv_i = 0, beat i presents (start + i) mod 2048. The burst does not end by itself.
- R6: last_o is high exactly on the final beat of a fixed-length burst. It is never high during a full-page burst, and never while valid_o is low.
- R7: When stop_i is high in a cycle with a valid beat, that beat is still presented, and valid_o is low in the next cycle unless a new burst was accepted.
- R8: An accepted start request during a burst abandons the old burst. The next cycle presents beat 0 of the new burst. A start request overrides stop_i in the same cycle.
- R9: A start request is rejected when page_mode_i = 0 with burst_len_i in 4..7, or when page_mode_i = 1 with wrap_ilv_i = 1. A rejected request leaves valid_o, col_o, last_o and any ongoing burst unchanged, and sets err_o. err_o stays high until reset.
- R10: While rst_n is low, and after reset until the first accepted start, valid_o, last_o and err_o are low and col_o is zero. col_o is zero in every cycle where valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Read or write command accepted; capture configuration |
| col_i | input | 11 | Starting column address |
| burst_len_i | input | 3 | Burst length code (0..3 supported) |
| wrap_ilv_i | input | 1 | 0 = incrementing wrap, 1 = interleaved wrap |
| page_mode_i | input | 1 | Full-page burst select |
| stop_i | input | 1 | Terminate the running burst after the current beat |
| col_o | output | 11 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Sticky flag: an unsupported start request was seen |

## Verification
The bench sweeps every start offset within the 8-column block, with several upper column values, across all four lengths and both wrap orders. A design that carried the low-bit sum into the upper bits, or that XORed with the wrong beat index, shows up on the first wrapping beat. A full-page burst is started near the top of the column space. This catches a counter that stops or clamps at 2047, and a last_o that leaks into full-page mode. Further cases cover stop and start in the same cycle, a restart in the middle of a burst, and a rejected request during a live burst. A design that lets a rejected request disturb the ongoing burst, or that gives stop_i priority over start_i, shows a wrong column or a missing beat at those points.

// File: rtl/bcag_pkg.sv
// Package: shared constants and the captured burst configuration type for
// the burst column address generator.
package bcag_pkg;
    localparam int CODE_W  = 3;   // width of the burst length code
    localparam int LG2_W   = 2;   // width of log2(burst length) for fixed bursts
    localparam int MAX_LG2 = 3;   // longest fixed burst is 2^MAX_LG2 beats

    typedef struct packed {
        logic             full;   // full-page burst
        logic             ilv;    // interleaved wrap order
        logic [LG2_W-1:0] lg2;    // log2 of fixed burst length
    } burst_cfg_t;
endpackage

// File: rtl/bcag_decode.sv
// Module: bcag_decode
// Turns the raw start request fields into a burst configuration and a
// legality flag. Purely combinational.
// Assumes: codes 0..MAX_LG2 are the supported fixed lengths; full-page
// requires incrementing order.
module bcag_decode
    import bcag_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              ilv_i,
    input  logic              full_i,
    output burst_cfg_t        cfg_o,
    output logic              legal_o
);
    // Legality and field packing for the request
    always_comb begin
        cfg_o.full = full_i;
        cfg_o.ilv  = ilv_i;
        cfg_o.lg2  = code_i[LG2_W-1:0];
        if (full_i) begin
            legal_o = !ilv_i;
        end else begin
            legal_o = (code_i <= CODE_W'(MAX_LG2));
        end
    end
endmodule

// File: rtl/bcag_seq.sv
// Module: bcag_seq
// Holds the active burst: starting column, configuration and beat index.
// Advances one beat per clock, ends on the last fixed beat or on stop.
// Assumes: an accepted start overrides stop in the same cycle; a rejected
// start is never presented with legal_i high.
module bcag_seq
    import bcag_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             legal_i,
    input  burst_cfg_t       cfg_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             stop_i,
    output logic             active_o,
    output logic             last_o,
    output logic [COL_W-1:0] idx_o,
    output logic [COL_W-1:0] base_o,
    output burst_cfg_t       cfg_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             active_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] len_m1;
    logic             is_last;

    // Final index of the current fixed burst and the last-beat decision
    always_comb begin
        len_m1  = (ONE << cfg_q.lg2) - ONE;
        is_last = active_q && !cfg_q.full && (idx_q == len_m1);
    end

    // Burst state: capture on accepted start, step or retire otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            base_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i && legal_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            base_q   <= col_i;
            cfg_q    <= cfg_i;
        end else if (active_q && (stop_i || is_last)) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (active_q) begin
            idx_q    <= idx_q + ONE;
        end
    end

    assign active_o = active_q;
    assign last_o   = is_last;
    assign idx_o    = idx_q;
    assign base_o   = base_q;
    assign cfg_o    = cfg_q;
endmodule

// File: rtl/bcag_map.sv
// Module: bcag_map
// Forms the column of the current beat from the start column and beat
// index. Bits inside the burst block take the incrementing sum or the XOR
// with the index; bits above the block keep the start column.
// Assumes: idx_i < burst length for fixed bursts, so XOR leaves upper bits.
module bcag_map
    import bcag_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             active_i,
    input  burst_cfg_t       cfg_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    output logic [COL_W-1:0] col_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] mix;
    logic [COL_W-1:0] pick;

    // Block mask and the two candidate orders
    always_comb begin
        mask = cfg_i.full ? '1 : ((ONE << cfg_i.lg2) - ONE);
        sum  = base_i + idx_i;
        mix  = base_i ^ idx_i;
    end

    // Per-bit choice between wrapped value and fixed start bit
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign pick[b] = mask[b] ? (cfg_i.ilv ? mix[b] : sum[b]) : base_i[b];
    end

    assign col_o = active_i ? pick : '0;
endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Burst column address generator: one column per clock for fixed bursts of
// 1/2/4/8 beats (incrementing or interleaved wrap) or endless full-page
// bursts, with terminate, restart and a sticky error on rejected requests.
// Assumes: synchronous active-low reset; first beat one cycle after start.
module burst_col_gen
    import bcag_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [CODE_W-1:0] burst_len_i,
    input  logic              wrap_ilv_i,
    input  logic              page_mode_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    burst_cfg_t       req_cfg;
    burst_cfg_t       cur_cfg;
    logic             start_legal;
    logic             active;
    logic             seq_last;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] base_col;
    logic             cur_full;
    logic             err_q;

    bcag_decode i_decode (
        .code_i  (burst_len_i),
        .ilv_i   (wrap_ilv_i),
        .full_i  (page_mode_i),
        .cfg_o   (req_cfg),
        .legal_o (start_legal)
    );

    bcag_seq #(.COL_W(COL_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .legal_i  (start_legal),
        .cfg_i    (req_cfg),
        .col_i    (col_i),
        .stop_i   (stop_i),
        .active_o (active),
        .last_o   (seq_last),
        .idx_o    (beat_idx),
        .base_o   (base_col),
        .cfg_o    (cur_cfg)
    );

    bcag_map #(.COL_W(COL_W)) i_map (
        .active_i (active),
        .cfg_i    (cur_cfg),
        .base_i   (base_col),
        .idx_i    (beat_idx),
        .col_o    (col_o)
    );

    // Sticky flag for rejected start requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start_i && !start_legal) begin
            err_q <= 1'b1;
        end
    end

    assign cur_full = cur_cfg.full;
    assign valid_o  = active;
    assign last_o   = seq_last;
    assign err_o    = err_q;
endmodule

// File: rtl/bcag_chk.sv
// Module: bcag_chk
// Property checker for burst_col_gen, attached through bind below.
module bcag_chk #(
    parameter int COL_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             legal,
    input logic             full_q,
    input logic [COL_W-1:0] col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && legal |=> valid_o && (col_o == $past(col_i))); // R1

    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && last_o && !start_i |=> !valid_o); // R2

    AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o && !stop_i && !start_i |=> valid_o); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !full_q && !last_o && !stop_i && !start_i
        |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])); // R3

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && full_q && !stop_i && !start_i
        |=> col_o == COL_W'($past(col_o) + COL_W'(1))); // R5

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o && !full_q); // R6

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !start_i |=> !valid_o); // R7

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !legal |=> err_o); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0) && !last_o); // R10
endmodule

bind burst_col_gen bcag_chk #(.COL_W(COL_W)) i_bcag_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .legal   (start_legal),
    .full_q  (cur_full),
    .col_i   (col_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .err_o   (err_o)
);

// File: tb/test_burst_col_gen.sv
// Bench for burst_col_gen: near-exhaustive sweep of offsets, lengths and
// wrap orders, plus full-page, stop, restart and rejected-request cases.
module test_burst_col_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] col = '0;
    logic [2:0]  code = '0;
    logic        ilv = 1'b0;
    logic        full = 1'b0;
    logic        stop = 1'b0;
    logic [10:0] col_o;
    logic        valid_o;
    logic        last_o;
    logic        err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .col_i       (col),
        .burst_len_i (code),
        .wrap_ilv_i  (ilv),
        .page_mode_i (full),
        .stop_i      (stop),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .err_o       (err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int base, input int cd, input bit il, input int i);
        int mask = (1 << cd) - 1;
        int low  = il ? (base ^ i) : (base + i);
        return (base & ~mask & 2047) | (low & mask);
    endfunction

    // Present a start request for one cycle; returns at the first beat
    task automatic launch(input int c, input int cd, input bit il, input bit fp);
        start = 1'b1; col = 11'(c); code = 3'(cd); ilv = il; full = fp;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full fixed burst, every beat checked, then idle checked
    task automatic run_fixed(input int c, input int cd, input bit il);
        int len = 1 << cd;
        launch(c, cd, il, 1'b0);
        for (int i = 0; i < len; i++) begin
            chk(i == 0 ? "R1 valid" : "R2 valid", int'(valid_o), 1);
            chk(il ? "R4 col" : "R3 col", int'(col_o), exp_col(c, cd, il, i));
            chk("R6 last", int'(last_o), (i == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R2 end", int'(valid_o), 0);
        chk("R10 idle col", int'(col_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset valid", int'(valid_o), 0);
        chk("R10 reset last", int'(last_o), 0);
        chk("R10 reset err", int'(err_o), 0);
        chk("R10 reset col", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset valid", int'(valid_o), 0);

        // Sweep: upper bases x offsets x lengths x orders (R2 R3 R4 R6)
        for (int bi = 0; bi < 3; bi++) begin
            for (int off = 0; off < 8; off++) begin
                for (int cd = 0; cd < 4; cd++) begin
                    for (int il = 0; il < 2; il++) begin
                        int base = (bi == 0) ? 0 : (bi == 1) ? 'h5A8 : 'h7F8;
                        run_fixed(base + off, cd, il[0]);
                    end
                end
            end
        end
        chk("R9 no err yet", int'(err_o), 0);

        // R5: full page wraps past 2047, no last
        launch(2045, 0, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            chk("R5 valid", int'(valid_o), 1);
            chk("R5 col", int'(col_o), (2045 + i) % 2048);
            chk("R6 page last", int'(last_o), 0);
            @(negedge clk);
        end
        // R7: stop ends the full page after the current beat
        stop = 1'b1;
        chk("R7 beat on stop", int'(col_o), (2045 + 8) % 2048);
        chk("R7 valid on stop", int'(valid_o), 1);
        @(negedge clk);
        stop = 1'b0;
        chk("R7 ended", int'(valid_o), 0);

        // R7: stop inside a fixed burst
        launch('h100, 3, 1'b0, 1'b0);
        @(negedge clk);
        stop = 1'b1;
        chk("R7 fixed beat", int'(col_o), 'h101);
        @(negedge clk);
        stop = 1'b0;
        chk("R7 fixed ended", int'(valid_o), 0);
        chk("R7 fixed last", int'(last_o), 0);

        // R8: restart mid-burst
        launch('h45, 3, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 old beat", int'(col_o), exp_col('h45, 3, 1'b1, 2));
        launch('h123, 2, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            chk("R8 new col", int'(col_o), exp_col('h123, 2, 1'b0, i));
            chk("R8 new last", int'(last_o), (i == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8 new end", int'(valid_o), 0);

        // R8: start overrides stop in the same cycle
        launch('h10, 3, 1'b0, 1'b0);
        stop = 1'b1;
        launch('h33, 1, 1'b0, 1'b0);
        stop = 1'b0;
        chk("R8 override valid", int'(valid_o), 1);
        chk("R8 override col", int'(col_o), 'h33);
        @(negedge clk);
        chk("R8 override col2", int'(col_o), 'h32);
        chk("R8 override last", int'(last_o), 1);
        @(negedge clk);
        chk("R8 override end", int'(valid_o), 0);

        // R9: rejected code during a live burst changes nothing
        launch('h200, 3, 1'b0, 1'b0);
        start = 1'b1; col = 11'h3FF; code = 3'd5; full = 1'b0; ilv = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i < 8; i++) begin
            chk("R9 burst kept", int'(col_o), exp_col('h200, 3, 1'b0, i));
            chk("R9 err", int'(err_o), 1);
            @(negedge clk);
        end
        chk("R9 burst end", int'(valid_o), 0);

        // R9: full page with interleave rejected while idle
        start = 1'b1; col = 11'h011; code = 3'd0; full = 1'b1; ilv = 1'b1;
        @(negedge clk);
        start = 1'b0; full = 1'b0; ilv = 1'b0;
        chk("R9 idle stays", int'(valid_o), 0);
        chk("R9 idle col", int'(col_o), 0);
        chk("R9 err held", int'(err_o), 1);

        // R10: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 err cleared", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule